// File: doc/BRIEF.md
# Button-Stepped Rotating Light Bar

This block drives a bar of LEDs with a band of adjacent lit positions that circulates around the bar at a fixed pace. A single push-button picks the band width. Each press widens the band by one position. After four widths it falls back to the narrowest one. The band is always placed back at the low end of the bar when its width changes. A direction input chooses which way the band travels.

The raw button is treated as an ordinary asynchronous data input. It crosses into the clock domain through a flop chain and is filtered by a stability counter. A registered detector then turns the filtered level's low-to-high change into a single-cycle strobe, and that strobe advances the width counter. Movement is paced by a free-running divider, so the band keeps moving whether the button is up, down or bouncing.

Top module: `led_chaser`

## Requirements
- R1: While reset is high, and on the first cycle after it drops, the output equals 0x0003: bits 0 and 1 lit, all others dark. The width counter is at its smallest value, 1.
- R2: The width counter k steps 1, 2, 3, 4, 1, … on each accepted press. On that press the output is rewritten with bits 0 through k lit (k+1 ones, so 0x0007, 0x000F, 0x001F, 0x0003) and every higher bit dark.
- R3: With `dir_left` = 0, each step moves the contents of bit i into bit i-1 and bit 0 into bit 15.
- R4: With `dir_left` = 1, each step moves the contents of bit i into bit i+1 and bit 15 into bit 0.
- R5: Holding the button down produces exactly one width change, and the band keeps moving while the button is held.
- R6: The filtered button level changes only after the synchronized input has differed from it on DEBOUNCE_CYC consecutive clocks. A shorter pulse or a burst of bounces changes nothing.
- R7: When a width change and a movement step fall on the same clock, the width change wins and that step is dropped. The output then shows the unrotated band.
- R8: Movement steps are exactly STEP_CYC clocks apart. A press adds 2 + DEBOUNCE_CYC + 2 clocks of latency from the raw input to the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the only clock in the block |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Unsynchronized, bouncing push-button level, high when pressed |
| dir_left | input | 1 | Travel direction: 1 toward bit 15, 0 toward bit 0 |
| led | output | LED_W (16) | Registered light-bar pattern |

## Verification
The bench builds the block with DEBOUNCE_CYC = 4 and STEP_CYC = 8 instead of the million-clock defaults. With these values, a full width cycle, glitches of one clock below the filter threshold and several movement periods all fit in a few thousand clocks. The short step period also lets the bench find the divider's phase from the output alone. It then times a press so that its width change lands on the same clock as a step, which exercises the priority rule from the ports.

// File: rtl/led_chaser_pkg.sv
package led_chaser_pkg;

  typedef logic [2:0] width_t;

  localparam width_t WIDTH_MIN = 3'd1;
  localparam width_t WIDTH_MAX = 3'd4;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/btn_filter.sv
module btn_filter #(
  parameter int HOLD_CYC = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] run_q;
  logic             level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (din == level_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      level_q <= din;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level = level_q;

  // R6: a new level is only ever the one the input has been presenting
  a_r6_level_from_input: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(din) == level_q));

  // R6: the run counter never passes the acceptance threshold
  a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
    (run_q <= LAST));

endmodule

// File: rtl/rise_strobe.sv
module rise_strobe (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic strobe
);

  logic prev_q;
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      prev_q   <= level;
      strobe_q <= level & ~prev_q;
    end
  end

  assign strobe = strobe_q;

  // R5: one strobe per press, never two in a row
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);

endmodule

// File: rtl/step_pacer.sv
module step_pacer #(
  parameter int PERIOD = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = tick_q;

  // R8: a tick is followed by a quiet gap
  a_r8_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);

endmodule

// File: rtl/led_chaser.sv
module led_chaser
  import led_chaser_pkg::*;
#(
  parameter int LED_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_CYC = 1_000_000,
  parameter int STEP_CYC     = 12_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_raw,
  input  logic             dir_left,
  output logic [LED_W-1:0] led
);

  logic btn_s;
  logic btn_clean;
  logic press;
  logic step;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (btn_raw), .dout (btn_s)
  );

  btn_filter #(.HOLD_CYC(DEBOUNCE_CYC)) u_filter (
    .clk (clk), .rst (rst), .din (btn_s), .level (btn_clean)
  );

  rise_strobe u_edge (
    .clk (clk), .rst (rst), .level (btn_clean), .strobe (press)
  );

  step_pacer #(.PERIOD(STEP_CYC)) u_pacer (
    .clk (clk), .rst (rst), .tick (step)
  );

  function automatic logic [LED_W-1:0] band_of(width_t k);
    logic [LED_W-1:0] m;
    for (int i = 0; i < LED_W; i++) m[i] = (i <= int'(k));
    return m;
  endfunction

  width_t           width_q;
  width_t           width_nxt;
  logic [LED_W-1:0] bar_q;

  always_comb width_nxt = (width_q == WIDTH_MAX) ? WIDTH_MIN : width_q + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= WIDTH_MIN;
      bar_q   <= band_of(WIDTH_MIN);
    end else if (press) begin
      width_q <= width_nxt;
      bar_q   <= band_of(width_nxt);
    end else if (step) begin
      bar_q <= dir_left ? {bar_q[LED_W-2:0], bar_q[LED_W-1]}
                        : {bar_q[0], bar_q[LED_W-1:1]};
    end
  end

  assign led = bar_q;

  // R2: width advances by one below the top value
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (press && width_q != WIDTH_MAX) |=> (width_q == $past(width_q) + 3'd1));

  // R2: width wraps from the top back to the bottom
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (press && width_q == WIDTH_MAX) |=> (width_q == WIDTH_MIN));

  // R7: a press always leaves the unrotated band, step or not
  a_r7_reload_wins: assert property (@(posedge clk) disable iff (rst)
    press |=> (bar_q == ~({LED_W{1'b1}} << (width_q + 3'd1))));

  // R3: rightward step
  a_r3_step_right: assert property (@(posedge clk) disable iff (rst)
    (step && !press && !dir_left) |=>
      (bar_q == {$past(bar_q[0]), $past(bar_q[LED_W-1:1])}));

  // R4: leftward step
  a_r4_step_left: assert property (@(posedge clk) disable iff (rst)
    (step && !press && dir_left) |=>
      (bar_q == {$past(bar_q[LED_W-2:0]), $past(bar_q[LED_W-1])}));

  // R8: without a step or press the bar holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !press) |=> $stable(bar_q));

endmodule

// File: tb/led_chaser_bench.sv
module led_chaser_bench;

  localparam int W    = 16;
  localparam int DB   = 4;
  localparam int STEP = 8;

  typedef struct packed {
    logic       is_press;
    logic       dir;
    logic [4:0] ones;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b0, 5'd2},
    '{1'b0, 1'b1, 5'd2},
    '{1'b1, 1'b0, 5'd3},
    '{1'b0, 1'b0, 5'd3},
    '{1'b1, 1'b0, 5'd4},
    '{1'b0, 1'b1, 5'd4},
    '{1'b1, 1'b0, 5'd5},
    '{1'b0, 1'b0, 5'd5},
    '{1'b1, 1'b0, 5'd2},
    '{1'b0, 1'b1, 5'd2}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         btn_raw = 1'b0;
  logic         dir_left = 1'b0;
  logic [W-1:0] led;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  led_chaser #(
    .LED_W(W), .SYNC_STAGES(2), .DEBOUNCE_CYC(DB), .STEP_CYC(STEP)
  ) u_led_chaser (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .dir_left(dir_left), .led(led)
  );

  function automatic logic [W-1:0] low_band(int n);
    return W'((32'd1 << n) - 1);
  endfunction

  function automatic logic [W-1:0] rot_r(logic [W-1:0] v);
    return {v[0], v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] rot_l(logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  function automatic bit is_band(logic [W-1:0] v, int n);
    logic [W-1:0] m;
    m = low_band(n);
    for (int k = 0; k < W; k++) begin
      if (v == m) return 1'b1;
      m = rot_l(m);
    end
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean_press();
    btn_raw = 1'b1;
    tick_n(20);
    btn_raw = 1'b0;
    tick_n(20);
  endtask

  task automatic move_check(logic d, int ones, string req);
    logic [W-1:0] a;
    dir_left = d;
    tick_n(2);
    a = led;
    tick_n(STEP);
    check(led == (d ? rot_l(a) : rot_r(a)), req, led, d ? rot_l(a) : rot_r(a));
    check($countones(led) == ones, req, W'($countones(led)), W'(ones));
  endtask

  initial begin
    tick_n(100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    int gap;

    tick_n(5);
    check(led == 16'h0003, "R1 during reset", led, 16'h0003);
    rst = 1'b0;
    @(negedge clk);
    check(led == 16'h0003, "R1 after reset", led, 16'h0003);

    foreach (VEC[i]) begin
      if (VEC[i].is_press) begin
        clean_press();
        check(is_band(led, VEC[i].ones), "R2 width step", led, low_band(VEC[i].ones));
      end else begin
        move_check(VEC[i].dir, VEC[i].ones, VEC[i].dir ? "R4 left" : "R3 right");
      end
    end

    // R5: long hold, movement continues and only one width change
    btn_raw = 1'b1;
    tick_n(20);
    move_check(1'b0, 3, "R5 moving while held");
    tick_n(60);
    btn_raw = 1'b0;
    tick_n(20);
    check(is_band(led, 3), "R5 one change per hold", led, low_band(3));

    // R6: pulses of 2 and DB-1 clocks are ignored
    btn_raw = 1'b1; tick_n(2); btn_raw = 1'b0; tick_n(20);
    check(is_band(led, 3), "R6 short glitch", led, low_band(3));
    btn_raw = 1'b1; tick_n(DB - 1); btn_raw = 1'b0; tick_n(20);
    check(is_band(led, 3), "R6 glitch one below threshold", led, low_band(3));

    // R6: bouncing press counts once
    for (int b = 0; b < 6; b++) begin
      btn_raw = ~btn_raw;
      tick_n(1);
    end
    btn_raw = 1'b1; tick_n(20);
    for (int b = 0; b < 6; b++) begin
      btn_raw = ~btn_raw;
      tick_n(1);
    end
    btn_raw = 1'b0; tick_n(20);
    check(is_band(led, 4), "R6 bouncy press", led, low_band(4));

    // R8: step spacing measured from the output
    dir_left = 1'b0;
    prev = led;
    do @(negedge clk); while (led == prev);
    prev = led;
    gap = 0;
    do begin @(negedge clk); gap++; end while (led == prev);
    check(gap == STEP, "R8 step spacing", W'(gap), W'(STEP));

    // R7: press timed so its width change lands on a step clock
    btn_raw = 1'b1;
    tick_n(2 + DB + 2);
    check(led == 16'h001F, "R7 reload beats step", led, 16'h001F);
    tick_n(12);
    btn_raw = 1'b0;
    tick_n(20);

    // R1: reset mid-run, then width restarts from 1
    rst = 1'b1;
    tick_n(2);
    rst = 1'b0;
    @(negedge clk);
    check(led == 16'h0003, "R1 reset mid-run", led, 16'h0003);
    clean_press();
    check(is_band(led, 3), "R2 first press after reset", led, low_band(3));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule